// File: doc/BRIEF.md
# Banked Register Array for an 8-bit Processor Core

This block holds every programmer-visible register of a small 8-bit processor. It provides six general-purpose byte registers and one accumulator/flag pair, each present twice as a main copy and an alternate copy. It also holds four 16-bit pointer registers (stack pointer, program counter and two index registers), a 7-bit-counting refresh register and an interrupt-vector byte. In total it stores 208 bits. Two combinational read ports and one clocked write port reach the storage. A single address bit chooses byte access or 16-bit pair access.

Two exchange strobes switch which copy is visible. One toggles the accumulator/flag bank and the other toggles the general-purpose bank. No data is moved, so each swap takes one cycle and keeps the contents of both copies. A refresh strobe advances the refresh register once per cycle. Instruction decode, arithmetic and bus timing belong to other blocks.

Address map (5 bits, bit 4 = pair mode):
- Byte mode, low 4 bits: 0..5 general bytes g0..g5, 6 accumulator, 7 flags, 8 refresh, 9 interrupt vector, 10..15 unmapped.
- Pair mode, low 4 bits: 0..2 general pairs {g0,g1}, {g2,g3}, {g4,g5} (even byte is the high half), 3 {accumulator,flags}, 4 stack pointer, 5 program counter, 6 index X, 7 index Y, 8..15 unmapped.

Top module: `regbank_top`

## Requirements
- R1: After reset every mapped register in both banks reads zero, the program counter included, and both bank selects point at the main copy.
- R2: A byte write with write enable high stores wrData[7:0] into the addressed byte of the active bank. It leaves the other byte of the same pair and all other registers unchanged. A byte read returns the value zero-extended to 16 bits.
- R3: A pair write stores wrData[15:8] into the even (high) byte and wrData[7:0] into the odd (low) byte in the same clock edge. A pair read returns {high, low}.
- R4: A pulse on xchgAf toggles only the accumulator/flag bank select. The contents of both accumulator/flag copies are kept, and the general-purpose view is unchanged.
- R5: A pulse on xchgGp toggles only the general-purpose bank select. The contents of both general copies are kept, and the accumulator/flag view is unchanged.
- R6: A write that coincides with an exchange strobe lands in the bank that was active before that clock edge.
- R7: The stack pointer, program counter and two index registers are written and read only as pairs, at pair codes 4 to 7. The refresh register and interrupt vector are byte registers at codes 8 and 9.
- R8: Each refInc pulse adds one to bits 6:0 of the refresh register, wrapping from 127 to 0, and keeps bit 7. A write to the refresh register in the same cycle takes priority over the increment.
- R9: A read of a register that is being written in the same cycle returns the value from before the write. The new value appears after the clock edge.
- R10: Reads of unmapped addresses return zero, and writes to them change no register.
- R11: The two read ports are independent: each returns the value at its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write address, bit 4 selects pair mode |
| wrData | input | 16 | Write data, low byte used in byte mode |
| xchgAf | input | 1 | Toggle accumulator/flag bank |
| xchgGp | input | 1 | Toggle general-purpose bank |
| refInc | input | 1 | Refresh register increment strobe |
| rdAddrA | input | 5 | Read port A address |
| rdDataA | output | 16 | Read port A data |
| rdAddrB | input | 5 | Read port B address |
| rdDataB | output | 16 | Read port B data |

## Verification
The hardest state to reach is one where all four combinations of the two bank selects hold distinct, known contents in every register. Only then can a wrong bank index or a copy instead of a toggle be seen. The bench steps through each select combination with exchange pulses and fills every byte and pair address with a pattern derived from the address and the combination. It then sweeps all 32 read addresses on both ports. It also issues a write in the same cycle as an exchange, and runs the refresh register through its 7-bit wrap with bit 7 set.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int GP_REGS = 6;
  localparam int GP_PAIRS = GP_REGS / 2;
  localparam int WIDE_REGS = 4;
  localparam int ADDR_W  = 5;
  localparam int IDX_W   = ADDR_W - 1;
  localparam int REF_CNT_W = BYTE_W - 1;

  // byte-mode codes
  localparam logic [IDX_W-1:0] CODE_ACC = IDX_W'(GP_REGS);
  localparam logic [IDX_W-1:0] CODE_FLG = IDX_W'(GP_REGS + 1);
  localparam logic [IDX_W-1:0] CODE_REF = IDX_W'(GP_REGS + 2);
  localparam logic [IDX_W-1:0] CODE_IV  = IDX_W'(GP_REGS + 3);
  // pair-mode codes
  localparam int PCODE_AF   = GP_PAIRS;
  localparam int PCODE_WIDE = GP_PAIRS + 1;

  typedef struct packed {
    logic [GP_REGS-1:0]   gpWe;
    logic                 accWe;
    logic                 flgWe;
    logic                 refWe;
    logic                 ivWe;
    logic [WIDE_REGS-1:0] wideWe;
    logic                 pairMode;
    logic                 afSel;
    logic                 gpSel;
    logic                 refStep;
  } strobes_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              xchgAf,
  input  logic              xchgGp,
  input  logic              refInc,
  output strobes_t          strb
);

  logic             afSel;
  logic             gpSel;
  logic             isPair;
  logic [IDX_W-1:0] idx;
  logic [GP_REGS-1:0]   gpHit;
  logic [WIDE_REGS-1:0] wideHit;

  assign isPair = wrAddr[ADDR_W-1];
  assign idx    = wrAddr[IDX_W-1:0];

  // bank select flip-flops: toggled, never copied
  always_ff @(posedge clk) begin
    if (rst) begin
      afSel <= 1'b0;
      gpSel <= 1'b0;
    end else begin
      if (xchgAf) afSel <= ~afSel;
      if (xchgGp) gpSel <= ~gpSel;
    end
  end

  genvar g;
  generate
    for (g = 0; g < GP_REGS; g++) begin : gGpDec
      assign gpHit[g] = wrEn && (isPair ? (idx == IDX_W'(g / 2)) : (idx == IDX_W'(g)));
    end
    for (g = 0; g < WIDE_REGS; g++) begin : gWideDec
      assign wideHit[g] = wrEn && isPair && (idx == IDX_W'(PCODE_WIDE + g));
    end
  endgenerate

  always_comb begin
    strb          = '0;
    strb.gpWe     = gpHit;
    strb.accWe    = wrEn && (isPair ? (idx == IDX_W'(PCODE_AF)) : (idx == CODE_ACC));
    strb.flgWe    = wrEn && (isPair ? (idx == IDX_W'(PCODE_AF)) : (idx == CODE_FLG));
    strb.refWe    = wrEn && !isPair && (idx == CODE_REF);
    strb.ivWe     = wrEn && !isPair && (idx == CODE_IV);
    strb.wideWe   = wideHit;
    strb.pairMode = isPair;
    strb.afSel    = afSel;
    strb.gpSel    = gpSel;
    strb.refStep  = refInc;
  end

  AST_AF_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    xchgAf |=> (afSel != $past(afSel))); // R4
  AST_AF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xchgAf |=> $stable(afSel)); // R5
  AST_GP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    xchgGp |=> (gpSel != $past(gpSel))); // R5
  AST_GP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xchgGp |=> $stable(gpSel)); // R4
  AST_BYTE_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !isPair) |-> $onehot0({strb.gpWe, strb.accWe, strb.flgWe,
                                    strb.refWe, strb.ivWe, strb.wideWe})); // R2
  AST_BYTE_NO_WIDE: assert property (@(posedge clk) disable iff (rst)
    !isPair |-> (strb.wideWe == '0)); // R7

endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB
);

  localparam int PORTS = 2;

  logic [BYTE_W-1:0] gpBank  [2][GP_REGS];
  logic [BYTE_W-1:0] accBank [2];
  logic [BYTE_W-1:0] flgBank [2];
  logic [WORD_W-1:0] wideReg [WIDE_REGS];
  logic [BYTE_W-1:0] refReg;
  logic [BYTE_W-1:0] ivReg;

  logic [BYTE_W-1:0] wrHi;
  logic [BYTE_W-1:0] wrLo;
  assign wrHi = wrData[WORD_W-1:BYTE_W];
  assign wrLo = wrData[BYTE_W-1:0];

  // general-purpose banks
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < GP_REGS; r++)
          gpBank[b][r] <= '0;
    end else begin
      for (int r = 0; r < GP_REGS; r++)
        if (strb.gpWe[r])
          gpBank[strb.gpSel][r] <= (strb.pairMode && (r % 2 == 0)) ? wrHi : wrLo;
    end
  end

  // accumulator / flag banks
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        accBank[b] <= '0;
        flgBank[b] <= '0;
      end
    end else begin
      if (strb.accWe) accBank[strb.afSel] <= strb.pairMode ? wrHi : wrLo;
      if (strb.flgWe) flgBank[strb.afSel] <= wrLo;
    end
  end

  // 16-bit pointer registers
  genvar w;
  generate
    for (w = 0; w < WIDE_REGS; w++) begin : gWide
      always_ff @(posedge clk) begin
        if (rst)                 wideReg[w] <= '0;
        else if (strb.wideWe[w]) wideReg[w] <= wrData;
      end
      AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strb.wideWe[w] |=> $stable(wideReg[w])); // R7
    end
  endgenerate

  // refresh counter and interrupt vector
  always_ff @(posedge clk) begin
    if (rst) begin
      refReg <= '0;
      ivReg  <= '0;
    end else begin
      if (strb.refWe)
        refReg <= wrLo;
      else if (strb.refStep)
        refReg <= {refReg[BYTE_W-1], refReg[REF_CNT_W-1:0] + REF_CNT_W'(1)};
      if (strb.ivWe) ivReg <= wrLo;
    end
  end

  // read multiplexers
  logic [ADDR_W-1:0] rdAddr [PORTS];
  logic [WORD_W-1:0] rdData [PORTS];
  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  genvar p;
  generate
    for (p = 0; p < PORTS; p++) begin : gRead
      logic             isPair;
      logic [IDX_W-1:0] idx;
      assign isPair = rdAddr[p][ADDR_W-1];
      assign idx    = rdAddr[p][IDX_W-1:0];

      always_comb begin
        rdData[p] = '0;
        if (isPair) begin
          for (int k = 0; k < GP_PAIRS; k++)
            if (idx == IDX_W'(k))
              rdData[p] = {gpBank[strb.gpSel][2*k], gpBank[strb.gpSel][2*k+1]};
          if (idx == IDX_W'(PCODE_AF))
            rdData[p] = {accBank[strb.afSel], flgBank[strb.afSel]};
          for (int k = 0; k < WIDE_REGS; k++)
            if (idx == IDX_W'(PCODE_WIDE + k))
              rdData[p] = wideReg[k];
        end else begin
          for (int k = 0; k < GP_REGS; k++)
            if (idx == IDX_W'(k))
              rdData[p] = {{BYTE_W{1'b0}}, gpBank[strb.gpSel][k]};
          if (idx == CODE_ACC) rdData[p] = {{BYTE_W{1'b0}}, accBank[strb.afSel]};
          if (idx == CODE_FLG) rdData[p] = {{BYTE_W{1'b0}}, flgBank[strb.afSel]};
          if (idx == CODE_REF) rdData[p] = {{BYTE_W{1'b0}}, refReg};
          if (idx == CODE_IV)  rdData[p] = {{BYTE_W{1'b0}}, ivReg};
        end
      end
    end
  endgenerate

  AST_REF_MSB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strb.refStep && !strb.refWe) |=> (refReg[BYTE_W-1] == $past(refReg[BYTE_W-1]))); // R8
  AST_REF_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
    (strb.refStep && !strb.refWe) |=>
      (refReg[REF_CNT_W-1:0] == REF_CNT_W'($past(refReg[REF_CNT_W-1:0]) + REF_CNT_W'(1)))); // R8
  AST_REF_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    strb.refWe |=> (refReg == $past(wrLo))); // R8
  AST_IV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.ivWe |=> $stable(ivReg)); // R10

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              xchgAf,
  input  logic              xchgGp,
  input  logic              refInc,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [WORD_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [WORD_W-1:0] rdDataB
);

  strobes_t strb;

  regbank_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .xchgAf (xchgAf),
    .xchgGp (xchgGp),
    .refInc (refInc),
    .strb   (strb)
  );

  regbank_dp uDp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrData  (wrData),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

endmodule

// File: tb/sim_regbank_top.sv
module sim_regbank_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        xchgAf = 1'b0;
  logic        xchgGp = 1'b0;
  logic        refInc = 1'b0;
  logic [4:0]  rdAddrA = '0;
  logic [4:0]  rdAddrB = '0;
  logic [15:0] rdDataA;
  logic [15:0] rdDataB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  regbank_top u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .xchgAf(xchgAf), .xchgGp(xchgGp), .refInc(refInc),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  // reference model, built from the requirements
  logic [7:0]  mGp [2][6];
  logic [7:0]  mAcc [2];
  logic [7:0]  mFlg [2];
  logic [15:0] mWide [4];
  logic [7:0]  mRef, mIv;
  bit          mAf, mGs;

  task automatic modelClear();
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 6; r++) mGp[b][r] = '0;
      mAcc[b] = '0; mFlg[b] = '0;
    end
    for (int k = 0; k < 4; k++) mWide[k] = '0;
    mRef = '0; mIv = '0; mAf = 0; mGs = 0;
  endtask

  function automatic logic [15:0] modelRead(logic [4:0] a);
    int i = int'(a[3:0]);
    if (a[4]) begin
      if (i < 3)  return {mGp[mGs][2*i], mGp[mGs][2*i+1]};
      if (i == 3) return {mAcc[mAf], mFlg[mAf]};
      if (i < 8)  return mWide[i-4];
      return 16'h0;
    end
    if (i < 6)  return {8'h0, mGp[mGs][i]};
    if (i == 6) return {8'h0, mAcc[mAf]};
    if (i == 7) return {8'h0, mFlg[mAf]};
    if (i == 8) return {8'h0, mRef};
    if (i == 9) return {8'h0, mIv};
    return 16'h0;
  endfunction

  task automatic modelWrite(logic [4:0] a, logic [15:0] d);
    int i = int'(a[3:0]);
    if (a[4]) begin
      if (i < 3) begin mGp[mGs][2*i] = d[15:8]; mGp[mGs][2*i+1] = d[7:0]; end
      else if (i == 3) begin mAcc[mAf] = d[15:8]; mFlg[mAf] = d[7:0]; end
      else if (i < 8) mWide[i-4] = d;
    end else begin
      if (i < 6) mGp[mGs][i] = d[7:0];
      else if (i == 6) mAcc[mAf] = d[7:0];
      else if (i == 7) mFlg[mAf] = d[7:0];
      else if (i == 8) mRef = d[7:0];
      else if (i == 9) mIv = d[7:0];
    end
  endtask

  // one clock with the given stimulus; inputs change 1 ns after the edge
  task automatic cycle(bit we, logic [4:0] a, logic [15:0] d, bit xa, bit xg, bit ri);
    wrEn = we; wrAddr = a; wrData = d; xchgAf = xa; xchgGp = xg; refInc = ri;
    @(posedge clk);
    if (we) modelWrite(a, d);
    if (ri && !(we && a == 5'd8)) mRef = {mRef[7], 7'(mRef[6:0] + 7'd1)};
    if (xa) mAf = !mAf;
    if (xg) mGs = !mGs;
    #1;
    wrEn = 0; xchgAf = 0; xchgGp = 0; refInc = 0;
  endtask

  task automatic check(bit portB, logic [4:0] a, string tag);
    logic [15:0] got, exp;
    if (portB) rdAddrB = a; else rdAddrA = a;
    #2;
    got = portB ? rdDataB : rdDataA;
    exp = modelRead(a);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s port%s addr=%0d actual=%h expected=%h", tag, portB ? "B" : "A", a, got, exp);
    end
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 32; a++) begin
      rdAddrA = 5'(a);
      rdAddrB = 5'(31 - a);
      #2;
      check(0, 5'(a), tag);
      check(1, 5'(31 - a), tag);
    end
  endtask

  task automatic selectBanks(bit af, bit gs);
    cycle(0, 5'd0, 16'h0, af != mAf, gs != mGs, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    modelClear();
    repeat (2) @(posedge clk);
    #1 rst = 0;

    // R1: reset state, both ports
    readAll("R1");

    // R2 R3 R7 R10 R11: fill every bank combination by bytes, then by pairs
    for (int c = 0; c < 4; c++) begin
      selectBanks(c[0], c[1]);
      for (int a = 0; a < 16; a++)
        cycle(1, 5'(a), 16'((a * 37 + c * 11 + 3) | 16'hA500), 0, 0, 0);
      readAll("R2/R7/R10/R11");
    end
    for (int c = 0; c < 4; c++) begin
      selectBanks(c[0], c[1]);
      for (int a = 0; a < 16; a++)
        cycle(1, 5'(16 + a), 16'(a * 4099 + c * 257 + 7), 0, 0, 0);
      readAll("R3/R7/R10/R11");
    end
    // byte write leaves pair partner intact
    selectBanks(0, 0);
    cycle(1, 5'd3, 16'hFF5A, 0, 0, 0);
    check(0, 5'd17, "R2");
    check(1, 5'd2, "R2");

    // R4: accumulator/flag exchange only
    cycle(0, 5'd0, 16'h0, 1, 0, 0);
    check(0, 5'd19, "R4");
    check(1, 5'd16, "R4");
    cycle(0, 5'd0, 16'h0, 1, 0, 0);
    check(0, 5'd19, "R4");

    // R5: general exchange only
    cycle(0, 5'd0, 16'h0, 0, 1, 0);
    check(0, 5'd18, "R5");
    check(1, 5'd19, "R5");
    cycle(0, 5'd0, 16'h0, 0, 1, 0);
    check(0, 5'd18, "R5");

    // R6: writes coinciding with exchanges land in the old bank
    cycle(1, 5'd0, 16'h00C3, 0, 1, 0);
    check(0, 5'd0, "R6");
    cycle(1, 5'd6, 16'h003C, 1, 0, 0);
    check(0, 5'd6, "R6");
    selectBanks(0, 0);
    check(0, 5'd0, "R6");
    check(1, 5'd6, "R6");

    // R8: refresh counter sweep with bit 7 set, wrap, then write priority
    cycle(1, 5'd8, 16'h00F0, 0, 0, 0);
    for (int s = 0; s < 140; s++) begin
      cycle(0, 5'd0, 16'h0, 0, 0, 1);
      check(0, 5'd8, "R8");
    end
    cycle(1, 5'd8, 16'h0011, 0, 0, 1);
    check(0, 5'd8, "R8");
    cycle(1, 5'd8, 16'h007F, 0, 0, 0);
    cycle(0, 5'd0, 16'h0, 0, 0, 1);
    check(0, 5'd8, "R8");

    // R9: same-cycle read returns the old value
    rdAddrA = 5'd21; rdAddrB = 5'd4;
    wrEn = 1; wrAddr = 5'd21; wrData = 16'h1234;
    check(0, 5'd21, "R9");
    @(posedge clk);
    modelWrite(5'd21, 16'h1234);
    #1 wrEn = 0;
    check(0, 5'd21, "R9");
    wrEn = 1; wrAddr = 5'd4; wrData = 16'h0099;
    check(1, 5'd4, "R9");
    @(posedge clk);
    modelWrite(5'd4, 16'h0099);
    #1 wrEn = 0;
    check(1, 5'd4, "R9");

    // R10: unmapped writes, then a full sweep
    cycle(1, 5'd12, 16'hDEAD, 0, 0, 0);
    cycle(1, 5'd27, 16'hBEEF, 0, 0, 0);
    readAll("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule